// File: doc/BRIEF.md
# Configurable 32-Input Interrupt Controller

This block gathers 32 interrupt request lines, turns each into a latched pending event, and presents the enabled events on two summary outputs: one for urgent (critical) service and one for ordinary (non-critical) service. Each line is set up on its own through a small register bus with an address, write data, a write strobe and combinational read data. Software chooses whether a line is sensed by level or by edge and which polarity counts as active. It also chooses which summary output the line drives.

Pending events stay latched in a status register until software writes ones to the matching bits. An enable register decides which pending events reach the outputs, and a read-only pending view returns status ANDed with enable. Because the ordinary summary output is a plain level, one instance can feed one input line of a parent instance, and the controllers can be stacked into a tree. A level-sensed event cannot be cleared while its source is still active, so a parent's pending bit stays set until the child has been serviced.

There is no state machine. The block has three kinds of state: a two-flop synchronizer and a last-value flop per line, the five writable registers, and the status latch. All of it changes on the clock edge, and all of it returns to zero on reset.

Top module: `irq_ctrl_unit`

## Requirements
- R1: Input line n (irq_in[n]) is held at register bit 31-n in every register, so line 0 sits at bit 31 and line 31 at bit 0.
- R2: Writing to the status register (address 0) clears each bit written as 1 and leaves bits written as 0 unchanged. Writing 0xFFFFFFFF clears every pending event whose source is not asserting in that cycle.
- R3: A trigger bit of 0 (trigger register, address 4) selects level sensing. The status bit is set on every cycle that the synchronized line is active, and if the source is still active a clear leaves the bit set.
- R4: A trigger bit of 1 selects edge sensing. The status bit is set once, when the synchronized line goes from inactive to active. A line that holds steady sets nothing.
- R5: A polarity bit of 1 (polarity register, address 3) makes high, or a rising edge, the active condition. A polarity bit of 0 makes low, or a falling edge, the active condition.
- R6: Address 5 reads status AND enable (enable register at address 1). A write to address 5 changes no register.
- R7: irq_noncrit_o is the OR of the pending-and-enabled bits whose critical-select bit (address 2) is 0. irq_crit_o is the OR of those whose critical-select bit is 1. With enable at zero, both outputs are low.
- R8: Reset sets enable, critical select, polarity and trigger to zero. Lines therefore default to active-low level sensing, and a line held low is pending again within 3 clocks of reset release.
- R9: When a child's irq_noncrit_o drives a parent's level-sensed, active-high line, the parent's pending bit cannot be cleared until the child's pending bit has been cleared. After that, a parent clear sticks.
- R10: Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | 32 | Interrupt request lines, asynchronous |
| irq_crit_o | output | 1 | Critical summary output |
| irq_noncrit_o | output | 1 | Non-critical summary output, for stacking into a parent |

## Verification
The bench builds two instances with the default NUM_IN of 32 and SYNC_STAGES of 2, and wires the child's non-critical output into line 5 of the parent. The full 32-bit width puts both ends of the reversed bit order (lines 0 and 31) in the vectors. The parent instance reaches the stacked clear order of R9, which no single instance can show. With two synchronizer stages the point at which an event becomes visible is fixed at three edges after the input changes. The bench relies on that latency when it places mixed level and edge vectors, polarity flips and clears that race a still-active source.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT  = 3'd0,
        REG_ENAB  = 3'd1,
        REG_CRIT  = 3'd2,
        REG_POLAR = 3'd3,
        REG_TRIG  = 3'd4,
        REG_PEND  = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/irqc_detect.sv
module irqc_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic pol_i,
    input  logic trig_i,
    output logic event_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            prev_q <= active;
        end
    end

    // active-high when pol is 1, active-low when pol is 0
    assign active  = sync_q[SYNC_STAGES-1] ~^ pol_i;
    assign event_o = trig_i ? (active & ~prev_q) : active;

    // R4: an edge event never fires two cycles running for an unchanged setup
    assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && $stable(pol_i) && event_o) |=> !(event_o && $stable(pol_i) && trig_i));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_IN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NUM_IN-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [NUM_IN-1:0] bus_rdata,
    input  logic [NUM_IN-1:0] event_vec,
    output logic [NUM_IN-1:0] stat_q,
    output logic [NUM_IN-1:0] en_q,
    output logic [NUM_IN-1:0] crit_q,
    output logic [NUM_IN-1:0] pol_q,
    output logic [NUM_IN-1:0] trig_q
);
    reg_addr_e         addr_e;
    logic [NUM_IN-1:0] clr_mask;

    assign addr_e   = reg_addr_e'(bus_addr);
    assign clr_mask = (bus_we && addr_e == REG_STAT) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
            crit_q <= '0;
            pol_q  <= '0;
            trig_q <= '0;
        end else begin
            // a new event wins over a clear in the same cycle
            stat_q <= (stat_q & ~clr_mask) | event_vec;
            if (bus_we) begin
                unique case (addr_e)
                    REG_ENAB:  en_q   <= bus_wdata;
                    REG_CRIT:  crit_q <= bus_wdata;
                    REG_POLAR: pol_q  <= bus_wdata;
                    REG_TRIG:  trig_q <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr_e)
            REG_STAT:  bus_rdata = stat_q;
            REG_ENAB:  bus_rdata = en_q;
            REG_CRIT:  bus_rdata = crit_q;
            REG_POLAR: bus_rdata = pol_q;
            REG_TRIG:  bus_rdata = trig_q;
            REG_PEND:  bus_rdata = stat_q & en_q;
            default:   bus_rdata = '0;
        endcase
    end

    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(clr_mask & ~event_vec)) == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(stat_q & ~clr_mask)) == $past(stat_q & ~clr_mask)));

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(event_vec)) == $past(event_vec)));

    assert_pend_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && addr_e == REG_PEND) |=>
            ($stable(en_q) && $stable(crit_q) && $stable(pol_q) && $stable(trig_q)));

    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > 3'd5) |-> (bus_rdata == '0));
endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
    parameter int NUM_IN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] stat_i,
    input  logic [NUM_IN-1:0] en_i,
    input  logic [NUM_IN-1:0] crit_i,
    output logic              irq_crit_o,
    output logic              irq_noncrit_o
);
    logic [NUM_IN-1:0] live;

    assign live          = stat_i & en_i;
    assign irq_crit_o    = |(live & crit_i);
    assign irq_noncrit_o = |(live & ~crit_i);

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> (!irq_crit_o && !irq_noncrit_o));

    assert_allcrit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_i == '1) |-> !irq_noncrit_o);
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
    import irqc_pkg::*;
#(
    parameter int NUM_IN      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NUM_IN-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [NUM_IN-1:0] bus_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic              irq_crit_o,
    output logic              irq_noncrit_o
);
    localparam int TOP_BIT = NUM_IN - 1;

    logic [NUM_IN-1:0] event_vec;
    logic [NUM_IN-1:0] stat_q, en_q, crit_q, pol_q, trig_q;

    // R1: line n lives at register bit NUM_IN-1-n
    for (genvar n = 0; n < NUM_IN; n++) begin : g_line
        irqc_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (irq_in[n]),
            .pol_i   (pol_q[TOP_BIT-n]),
            .trig_i  (trig_q[TOP_BIT-n]),
            .event_o (event_vec[TOP_BIT-n])
        );
    end

    irqc_regs #(.NUM_IN(NUM_IN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .event_vec (event_vec),
        .stat_q    (stat_q),
        .en_q      (en_q),
        .crit_q    (crit_q),
        .pol_q     (pol_q),
        .trig_q    (trig_q)
    );

    irqc_route #(.NUM_IN(NUM_IN)) u_route (
        .clk           (clk),
        .rst_n         (rst_n),
        .stat_i        (stat_q),
        .en_i          (en_q),
        .crit_i        (crit_q),
        .irq_crit_o    (irq_crit_o),
        .irq_noncrit_o (irq_noncrit_o)
    );
endmodule

// File: tb/irq_ctrl_unit_bench.sv
module irq_ctrl_unit_bench;
    localparam int W = 32;

    typedef struct packed {
        logic [W-1:0] pol, trig, en, crit, in_a, in_b, exp_pend;
    } vec_t;

    // values in register-bit space; exp_pend worked out from R3, R4, R5
    localparam vec_t VECS [7] = '{
        '{32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h80000001, 32'h80000001},
        '{32'h00000000, 32'h00000000, 32'h0000FFFF, 32'h00000000, 32'hFFFFFFFF, 32'hFFFF00FF, 32'h0000FF00},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hF0000000, 32'h00000000, 32'hF000000F, 32'hF000000F},
        '{32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0FFFFFFF, 32'hF0000000},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h00000000},
        '{32'hFFFF0000, 32'h00FF00FF, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFF00},
        '{32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00000000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   bus_addr = '0, p_addr = '0;
    logic [W-1:0] bus_wdata = '0, p_wdata = '0;
    logic         bus_we = 1'b0, p_we = 1'b0;
    logic [W-1:0] bus_rdata, p_rdata;
    logic [W-1:0] irq_in = '0;
    logic         irq_crit_o, irq_noncrit_o, p_crit, p_noncrit;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_ctrl_unit u_irq_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_crit_o(irq_crit_o), .irq_noncrit_o(irq_noncrit_o)
    );

    irq_ctrl_unit u_parent (
        .clk(clk), .rst_n(rst_n), .bus_addr(p_addr), .bus_wdata(p_wdata),
        .bus_we(p_we), .bus_rdata(p_rdata), .irq_in({26'd0, irq_noncrit_o, 5'd0}),
        .irq_crit_o(p_crit), .irq_noncrit_o(p_noncrit)
    );

    // register-bit space value to line vector (R1: line n at bit 31-n)
    function automatic logic [W-1:0] to_lines(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int n = 0; n < W; n++) r[n] = v[W-1-n];
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pwr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        p_addr = a; p_wdata = d; p_we = 1'b1;
        @(negedge clk);
        p_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic prd(input logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk);
        p_addr = a;
        #1 p_rdata_copy(d);
    endtask

    task automatic p_rdata_copy(output logic [W-1:0] d);
        d = p_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d;
        logic exp_nc, exp_cr;
        idle(3);
        rst_n = 1'b1;

        // R8: reset values
        rd(3'd1, d); check("R8 enable reset", d, '0);
        rd(3'd2, d); check("R8 critsel reset", d, '0);
        rd(3'd3, d); check("R8 polarity reset", d, '0);
        rd(3'd4, d); check("R8 trigger reset", d, '0);
        idle(3);
        rd(3'd0, d); check("R8 low lines pend by default", d, 32'hFFFFFFFF);
        check("R7 outputs low when disabled", {30'd0, irq_crit_o, irq_noncrit_o}, '0);

        // vector table: R3 R4 R5 R6 R7
        for (int v = 0; v < 7; v++) begin
            wr(3'd3, VECS[v].pol);
            wr(3'd4, VECS[v].trig);
            wr(3'd2, VECS[v].crit);
            wr(3'd1, VECS[v].en);
            irq_in = to_lines(VECS[v].in_a);
            idle(5);
            wr(3'd0, 32'hFFFFFFFF);
            idle(2);
            irq_in = to_lines(VECS[v].in_b);
            idle(5);
            rd(3'd5, d);
            check($sformatf("R3 R4 R5 R6 vector %0d pending", v), d, VECS[v].exp_pend);
            exp_nc = |(VECS[v].exp_pend & ~VECS[v].crit);
            exp_cr = |(VECS[v].exp_pend & VECS[v].crit);
            check($sformatf("R7 vector %0d noncrit", v), {31'd0, irq_noncrit_o}, {31'd0, exp_nc});
            check($sformatf("R7 vector %0d crit", v), {31'd0, irq_crit_o}, {31'd0, exp_cr});
        end

        // R1: only line 0 high, level active-high
        wr(3'd3, 32'hFFFFFFFF); wr(3'd4, 32'h0); wr(3'd2, 32'h0); wr(3'd1, 32'hFFFFFFFF);
        irq_in = '0; idle(5);
        wr(3'd0, 32'hFFFFFFFF);
        irq_in = 32'h00000001; idle(5);
        rd(3'd0, d); check("R1 line 0 at bit 31", d, 32'h80000000);

        // R3: clear while source active does not stick; sticks after release
        wr(3'd0, 32'hFFFFFFFF); idle(1);
        rd(3'd0, d); check("R3 clear while active", d, 32'h80000000);
        irq_in = '0; idle(5);
        wr(3'd0, 32'hFFFFFFFF); idle(1);
        rd(3'd0, d); check("R3 clear after release", d, 32'h0);

        // R2: partial clear with edge sensing on lines 0 and 31
        wr(3'd4, 32'hFFFFFFFF); idle(5);
        wr(3'd0, 32'hFFFFFFFF);
        irq_in = 32'h80000001; idle(5);
        wr(3'd0, 32'h00000001); idle(1);
        rd(3'd0, d); check("R2 partial clear", d, 32'h80000000);
        wr(3'd0, 32'hFFFFFFFF); idle(1);
        rd(3'd0, d); check("R2 full clear", d, 32'h0);

        // R6: write to pending view changes nothing
        wr(3'd1, 32'h0000FFFF);
        wr(3'd5, 32'hFFFFFFFF);
        rd(3'd1, d); check("R6 write to pending ignored", d, 32'h0000FFFF);
        rd(3'd0, d); check("R6 status untouched", d, 32'h0);

        // R10: unmapped addresses
        rd(3'd6, d); check("R10 addr 6 reads zero", d, 32'h0);
        rd(3'd7, d); check("R10 addr 7 reads zero", d, 32'h0);

        // R9: stacked clear order (child line 0 -> parent line 5, bit 26)
        irq_in = '0;
        wr(3'd3, 32'hFFFFFFFF); wr(3'd4, 32'h0); wr(3'd2, 32'h0); wr(3'd1, 32'h80000000);
        pwr(3'd3, 32'hFFFFFFFF); pwr(3'd4, 32'h0); pwr(3'd2, 32'h0); pwr(3'd1, 32'h04000000);
        idle(5);
        wr(3'd0, 32'hFFFFFFFF); pwr(3'd0, 32'hFFFFFFFF);
        irq_in = 32'h00000001; idle(10);
        prd(3'd0, d); check("R9 parent pends on child", d, 32'h04000000);
        check("R9 parent noncrit high", {31'd0, p_noncrit}, 32'd1);
        pwr(3'd0, 32'hFFFFFFFF); idle(1);
        prd(3'd0, d); check("R9 parent clear before child", d, 32'h04000000);
        irq_in = '0; idle(5);
        wr(3'd0, 32'hFFFFFFFF); idle(6);
        pwr(3'd0, 32'hFFFFFFFF); idle(1);
        prd(3'd0, d); check("R9 parent clear after child", d, 32'h0);
        check("R9 parent noncrit low", {31'd0, p_noncrit}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule